// File: doc/BRIEF.md
# Latency-Annotated Model Channel

This block joins a producer model and a consumer model that simulate a synchronous target, and it stands for a target path whose delay is a fixed number of model cycles. The delay is set by the parameter `LATENCY`. The channel is a first-in first-out queue. Each slot holds a payload plus one extra bit. When that bit is set, the slot holds an explicit "nothing was sent" token. Such a token is not the same as a missing entry: it takes up a slot and the consumer must remove it like any data word.

Model time is tracked by counting tokens rather than by timestamps. Reset fills the queue with `LATENCY` empty tokens, so the consumer can read that many model cycles before the producer's first word arrives. Per model cycle, the producer writes one entry and the consumer removes one. The channel reports its fill level against `LATENCY` as one of three levels: on target, ahead (more entries than the latency) or behind (fewer entries). A scheduler uses this level to decide which side should run next while draining or rebalancing the model.

Top module: `lat_chan`

## Requirements
- R1: Every slot is `PAYLOAD_W`+1 bits wide. The head outputs present the oldest accepted entry: its empty-token bit on `head_empty_tok_o` and its payload on `head_data_o`, in first-in first-out order.
- R2: An entry written with `push_empty_tok_i`=1 counts toward the fill level exactly like data. It stays at the head until the consumer pops it.
- R3: After reset the channel holds exactly `LATENCY` entries, and every one of them has the empty-token bit set and a zero payload.
- R4: Storage depth is `LATENCY`+1+`EXTRA_DEPTH`. `full_o` is 1 exactly when the channel holds that many entries. `empty_o` is 1 exactly when it holds none.
- R5: `level_o` is 2'b00 when the fill equals `LATENCY`, 2'b01 when the fill is greater, and 2'b10 when it is smaller. The value 2'b11 never appears.
- R6: A push while `full_o` is 1 writes nothing and sets `proto_err_o`.
- R7: A pop while `empty_o` is 1 removes nothing and sets `proto_err_o`. `proto_err_o` then stays at 1 until reset.
- R8: When a push and a pop are both accepted in the same clock, the fill level does not change.
- R9: With `LATENCY`=0 the channel starts empty, so the consumer must wait until the producer has written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the preload tokens |
| push_i | input | 1 | Producer writes one entry this clock |
| push_empty_tok_i | input | 1 | The written entry is an empty token |
| push_data_i | input | PAYLOAD_W | Payload of the written entry |
| pop_i | input | 1 | Consumer removes the head entry this clock |
| head_empty_tok_o | output | 1 | Empty-token bit of the head entry |
| head_data_o | output | PAYLOAD_W | Payload of the head entry |
| full_o | output | 1 | All slots are occupied |
| empty_o | output | 1 | No slot is occupied |
| level_o | output | 2 | Fill compared with LATENCY: 00 on target, 01 ahead, 10 behind |
| proto_err_o | output | 1 | Sticky flag for a rejected push or pop |

## Verification
The bench builds two copies of the block and drives them with the same stimulus. The first copy has `LATENCY`=2 and `EXTRA_DEPTH`=1, which gives four slots. Every fill from zero to full, all three levels, and pointer wrap-around on a power-of-two depth are reached within a few clocks. The second copy has `LATENCY`=0 and `EXTRA_DEPTH`=0, which leaves a single slot. That copy starts empty, exercises the pointer variant for depths that are not a power of two, and is constantly toggling between full and empty. Eight reset-separated runs use different push and pop densities, so overflow, underflow, simultaneous push and pop, and reset in the middle of traffic are all reached for both copies.

// File: rtl/lat_chan_pkg.sv
package lat_chan_pkg;

   typedef enum logic [1:0] {
      LVL_ON_TARGET = 2'b00,
      LVL_AHEAD     = 2'b01,
      LVL_BEHIND    = 2'b10
   } lvl_e;

   function automatic lvl_e classify(input int unsigned fill, input int unsigned lat);
      if (fill == lat)     return LVL_ON_TARGET;
      else if (fill > lat) return LVL_AHEAD;
      else                 return LVL_BEHIND;
   endfunction

endpackage

// File: rtl/lat_chan_store.sv
module lat_chan_store #(
   parameter int PAYLOAD_W = 8,
   parameter int DEPTH     = 4,
   parameter int PTR_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [PTR_W-1:0]     wr_idx,
   input  logic                 wr_tok,
   input  logic [PAYLOAD_W-1:0] wr_data,
   input  logic [PTR_W-1:0]     rd_idx,
   output logic                 rd_tok,
   output logic [PAYLOAD_W-1:0] rd_data
);
   localparam int SLOT_W = PAYLOAD_W + 1;

   logic [SLOT_W-1:0] slot_q [DEPTH];

   // Every slot resets to an empty token; only the first LATENCY ones are counted live.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[g] <= {1'b1, {PAYLOAD_W{1'b0}}};
         else if (wr_en && (wr_idx == PTR_W'(g)))
            slot_q[g] <= {wr_tok, wr_data};
      end
   end

   logic [SLOT_W-1:0] head_w;
   always_comb begin
      head_w = slot_q[0];
      for (int i = 0; i < DEPTH; i++)
         if (rd_idx == PTR_W'(i)) head_w = slot_q[i];
   end

   assign rd_tok  = head_w[SLOT_W-1];
   assign rd_data = head_w[PAYLOAD_W-1:0];

endmodule

// File: rtl/lat_chan_ptr.sv
module lat_chan_ptr #(
   parameter int DEPTH   = 4,
   parameter int LATENCY = 2,
   parameter int PTR_W   = 2,
   parameter int CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_push,
   input  logic             do_pop,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] fill
);
   localparam bit POW2 = (DEPTH > 1) && (DEPTH == (1 << PTR_W));

   logic [PTR_W-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CNT_W-1:0] fill_q;

   if (POW2) begin : g_wrap_free
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nx = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= PTR_W'(LATENCY % DEPTH);
         rd_q   <= '0;
         fill_q <= CNT_W'(LATENCY);
      end else begin
         if (do_push) wr_q <= wr_nx;
         if (do_pop)  rd_q <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   assign wr_idx = wr_q;
   assign rd_idx = rd_q;
   assign fill   = fill_q;

endmodule

// File: rtl/lat_chan_level.sv
module lat_chan_level
   import lat_chan_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int LATENCY = 2,
   parameter int CNT_W   = 3
) (
   input  logic [CNT_W-1:0] fill,
   output logic             full,
   output logic             empty,
   output logic [1:0]       level
);
   lvl_e lvl_w;

   always_comb begin
      lvl_w = classify(int'(fill), LATENCY);
   end

   assign full  = (fill == CNT_W'(DEPTH));
   assign empty = (fill == '0);
   assign level = lvl_w;

endmodule

// File: rtl/lat_chan.sv
module lat_chan #(
   parameter int PAYLOAD_W   = 8,
   parameter int LATENCY     = 2,
   parameter int EXTRA_DEPTH = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic                 push_empty_tok_i,
   input  logic [PAYLOAD_W-1:0] push_data_i,
   input  logic                 pop_i,
   output logic                 head_empty_tok_o,
   output logic [PAYLOAD_W-1:0] head_data_o,
   output logic                 full_o,
   output logic                 empty_o,
   output logic [1:0]           level_o,
   output logic                 proto_err_o
);
   localparam int DEPTH = LATENCY + 1 + EXTRA_DEPTH;
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (PAYLOAD_W < 1) begin : g_bad_width
      $error("lat_chan: PAYLOAD_W must be at least 1");
   end
   if (LATENCY < 0) begin : g_bad_lat
      $error("lat_chan: LATENCY must not be negative");
   end
   if (EXTRA_DEPTH < 0) begin : g_bad_extra
      $error("lat_chan: EXTRA_DEPTH must not be negative");
   end

   logic             full_w, empty_w, do_push, do_pop, err_q;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [CNT_W-1:0] fill;

   assign do_push = push_i && !full_w;
   assign do_pop  = pop_i && !empty_w;

   lat_chan_ptr #(
      .DEPTH(DEPTH), .LATENCY(LATENCY), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) ptr_i (
      .clk(clk), .rst_n(rst_n), .do_push(do_push), .do_pop(do_pop),
      .wr_idx(wr_idx), .rd_idx(rd_idx), .fill(fill)
   );

   lat_chan_store #(
      .PAYLOAD_W(PAYLOAD_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(do_push), .wr_idx(wr_idx),
      .wr_tok(push_empty_tok_i), .wr_data(push_data_i), .rd_idx(rd_idx),
      .rd_tok(head_empty_tok_o), .rd_data(head_data_o)
   );

   lat_chan_level #(
      .DEPTH(DEPTH), .LATENCY(LATENCY), .CNT_W(CNT_W)
   ) level_i (
      .fill(fill), .full(full_w), .empty(empty_w), .level(level_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else if ((push_i && full_w) || (pop_i && empty_w)) err_q <= 1'b1;
   end

   assign full_o      = full_w;
   assign empty_o     = empty_w;
   assign proto_err_o = err_q;

endmodule

// File: rtl/lat_chan_chk.sv
module lat_chan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       push_i,
   input logic       pop_i,
   input logic       full_o,
   input logic       empty_o,
   input logic [1:0] level_o,
   input logic       proto_err_o
);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o) |=> proto_err_o);

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> proto_err_o);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);

   assert_hold_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !full_o && !empty_o) |=>
         ($stable(level_o) && $stable(full_o) && $stable(empty_o)));

   assert_level_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      level_o != 2'b11);

   assert_full_ahead_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> (level_o == 2'b01));

   assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

   assert_empty_tok_after_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && pop_i && !empty_o && full_o) |=> !full_o);
endmodule

bind lat_chan lat_chan_chk chk_i (
   .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
   .full_o(full_o), .empty_o(empty_o), .level_o(level_o),
   .proto_err_o(proto_err_o)
);

// File: tb/lat_chan_tb_top.sv
`timescale 1ns/1ps
module lat_chan_tb_top;
   localparam int W = 8;
   localparam int LAT [2] = '{2, 0};
   localparam int DEP [2] = '{4, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push = 1'b0, tok = 1'b0, pop = 1'b0;
   logic [W-1:0] data = '0;

   always #4 clk = ~clk;

   logic         o_tok  [2];
   logic [W-1:0] o_data [2];
   logic         o_full [2], o_empty [2], o_err [2];
   logic [1:0]   o_lvl  [2];

   lat_chan #(.PAYLOAD_W(W), .LATENCY(2), .EXTRA_DEPTH(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_empty_tok_i(tok),
      .push_data_i(data), .pop_i(pop), .head_empty_tok_o(o_tok[0]),
      .head_data_o(o_data[0]), .full_o(o_full[0]), .empty_o(o_empty[0]),
      .level_o(o_lvl[0]), .proto_err_o(o_err[0]));

   lat_chan #(.PAYLOAD_W(W), .LATENCY(0), .EXTRA_DEPTH(0)) dut0_i (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_empty_tok_i(tok),
      .push_data_i(data), .pop_i(pop), .head_empty_tok_o(o_tok[1]),
      .head_data_o(o_data[1]), .full_o(o_full[1]), .empty_o(o_empty[1]),
      .level_o(o_lvl[1]), .proto_err_o(o_err[1]));

   int n_chk = 0, n_fail = 0;
   logic [W:0] mq [2][8];
   int mc [2];
   bit merr [2];
   logic [15:0] lfsr = 16'hACE1;
   int cyc = 0;

   task automatic check(input string req, input int k, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s dut%0d: actual %0d expected %0d", req, k, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         mc[k] = LAT[k];
         merr[k] = 1'b0;
         for (int i = 0; i < 8; i++) mq[k][i] = {1'b1, {W{1'b0}}};
      end
   endtask

   task automatic check_all();
      for (int k = 0; k < 2; k++) begin
         int exp_lvl;
         exp_lvl = (mc[k] == LAT[k]) ? 0 : (mc[k] > LAT[k]) ? 1 : 2;
         check("R4 full", k, int'(o_full[k]), int'(mc[k] == DEP[k]));
         check("R4 empty", k, int'(o_empty[k]), int'(mc[k] == 0));
         check("R5 R8 level", k, int'(o_lvl[k]), exp_lvl);
         check("R6 R7 proto_err", k, int'(o_err[k]), int'(merr[k]));
         if (mc[k] > 0) begin
            check("R1 R2 head token", k, int'(o_tok[k]), int'(mq[k][0][W]));
            check("R1 head data", k, int'(o_data[k]), int'(mq[k][0][W-1:0]));
         end
      end
   endtask

   task automatic model_step(input bit p, input bit t, input logic [W-1:0] d, input bit q);
      for (int k = 0; k < 2; k++) begin
         bit full, empty;
         full = (mc[k] == DEP[k]);
         empty = (mc[k] == 0);
         if ((p && full) || (q && empty)) merr[k] = 1'b1;
         if (q && !empty) begin
            for (int i = 0; i < 7; i++) mq[k][i] = mq[k][i+1];
            mc[k]--;
         end
         if (p && !full) begin
            mq[k][mc[k]] = {t, d};
            mc[k]++;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; push = 0; pop = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      // R3 R9: preload count, tokens and start level
      check("R3 R9 empty after reset", 0, int'(o_empty[0]), 0);
      check("R3 R9 empty after reset", 1, int'(o_empty[1]), 1);
      check("R3 preload token", 0, int'(o_tok[0]), 1);
      check("R3 preload level", 0, int'(o_lvl[0]), 0);
      check("R9 level lat0", 1, int'(o_lvl[1]), 0);
   endtask

   task automatic step(input bit p, input bit t, input logic [W-1:0] d, input bit q);
      push = p; tok = t; data = d; pop = q;
      @(posedge clk);
      model_step(p, t, d, q);
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         finish_run();
      end
   end

   initial begin
      do_reset();
      // directed: drain the preload (R2 tokens consumed like data), then starve (R7)
      step(0, 0, 8'h00, 1);
      step(0, 0, 8'h00, 1);
      step(1, 0, 8'h5A, 1);
      step(1, 1, 8'h33, 0);
      step(1, 0, 8'hC3, 1);
      // directed: overfill (R6)
      for (int i = 0; i < 6; i++) step(1, i[0], 8'(8'h10 + i), 0);
      for (int run = 0; run < 8; run++) begin
         int thp, thq;
         do_reset();
         thp = 4 + 2 * run;
         thq = 18 - 2 * run;
         for (int s = 0; s < 300; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'(lfsr[3:0]) < thp, lfsr[1], lfsr[15:8], int'(lfsr[7:4]) < thq);
         end
      end
      finish_run();
   end
endmodule